// File: doc/BRIEF.md
# Tiered link error recovery controller

This block is the sequencing state machine that a memory controller uses when the CRC check on its five lock-step channels fails. A recovery starts either when the memory side reports a poisoned CRC or when the controller detects a bad CRC itself. The controller then blocks new operations and waits until the operations already in flight have drained. It sends a poison code downstream and lets the links settle for a fixed interval. It acknowledges the error and finally tells the queues to resend pending stores and any fetches that were in flight.

How deep a recovery goes depends on history. Errors are counted inside a sliding idle window. A first or occasional error gets a plain retry. Once the count reaches a threshold, the failing channel is also re-initialised. An error that follows a recent re-initialisation takes the channel out of service: the block runs the remaining channels in redundancy-degraded mode, re-initialises them slowly, starts a scrub pass and raises a sticky service request. Further errors in degraded mode quiesce the channels and force a fast re-init. Hang timers guard every wait on the outside world. A timeout in the drain or channel re-init escalates the tier, and a timeout during the last tier is fatal.

The block also tells the store queue when a store may retire. This happens after a fixed wait during which no CRC error was seen. Links, queues and the scrub engine are outside the block and appear only as level handshakes.

Top module: `link_recovery_ctrl`

## Requirements
- R1: After reset every output is low, `current_tier` is 0 and no degraded channel, service request or fatal flag is shown.
- R2: While idle, `poison_in` or `crc_err` asserts `halt_new_ops` from the next cycle until the recovery ends. `send_poison` is not raised before `ops_drained` has been seen high; when it is already high, `send_poison` follows one cycle after the halt.
- R3: `send_poison` is a one-cycle pulse, and `error_ack` rises exactly `SETTLE_CYC`+1 cycles after `send_poison` rose.
- R4: `current_tier` is 0 when idle and gives the tier during a recovery. Tier 1 gives a single `retry_stores` pulse the cycle after `error_ack`. Tier 2 is chosen when this error brings the windowed count to `ERR_THRESH`; it holds `reinit_channel` with `reinit_ch_idx` equal to the failing `err_ch` after the acknowledge until `reinit_done`, then pulses `retry_stores`.
- R5: The error count and the recent-tier-2 memory both clear after `WINDOW_CYC` idle cycles without an error, so the next error is tier 1 again.
- R6: An error while a tier-2 recovery is recent selects tier 3. This tier 3 path runs as follows:
  - `degraded_valid` goes high with `degraded_idx` equal to the failing channel, and both stay fixed from then on.
  - `reinit_all` is held until `reinit_done`.
  - `start_scrub` pulses once, and the block waits for `scrub_done`.
  - `call_home` is then set and stays set, and `retry_stores` pulses.
- R7: In degraded mode, any error runs tier 3 as a quiesce. After the acknowledge, `reinit_all` is held until `reinit_done`, then `retry_stores` pulses; the degraded channel index does not change.
- R8: When `ops_drained` is still low `HANG_CYC` cycles into the drain, the tier rises by one and the block proceeds to the poison step. When a tier-2 re-init stays unfinished for `HANG_CYC` cycles, the block moves into the tier-3 path. That path marks the channel degraded and asserts `reinit_all` `HANG_CYC` cycles after `reinit_channel` rose.
- R9: A hang timeout in any tier-3 wait sets `fatal`. From then on `fatal` and `halt_new_ops` stay high, `current_tier` is 3 and no retry is issued until reset.
- R10: `store_retire` pulses for one cycle `STORE_WAIT` cycles after the clock edge that sampled `store_issue`, unless a CRC error was seen in between. An error cancels that retire.
- R11: A CRC error that arrives while a recovery is already running neither restarts the sequence nor adds to the error count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poison_in | input | 1 | Poisoned CRC reported from the memory side |
| crc_err | input | 1 | CRC error detected locally on returned data |
| err_ch | input | CH_W | Channel index that carried the error |
| ops_drained | input | 1 | All operations issued before the halt have completed |
| store_issue | input | 1 | A store was sent downstream this cycle |
| reinit_done | input | 1 | The requested channel re-init has finished |
| scrub_done | input | 1 | The scrub pass has finished |
| halt_new_ops | output | 1 | Block issue of new operations |
| send_poison | output | 1 | Send poison CRC downstream (one cycle) |
| error_ack | output | 1 | Send error acknowledge (one cycle) |
| retry_stores | output | 1 | Resend pending stores and in-flight fetches (one cycle) |
| reinit_channel | output | 1 | Re-initialise the single channel in `reinit_ch_idx` |
| reinit_ch_idx | output | CH_W | Channel to re-initialise |
| reinit_all | output | 1 | Re-initialise all channels still in service |
| degraded_valid | output | 1 | One channel is out of service |
| degraded_idx | output | CH_W | Channel taken out of service |
| start_scrub | output | 1 | Launch a scrub pass (one cycle) |
| call_home | output | 1 | Sticky service request for the degraded channel |
| fatal | output | 1 | Recovery failed in the last tier |
| store_retire | output | 1 | Newest store is past its poison wait (one cycle) |
| current_tier | output | 2 | Tier of the recovery in progress, 0 when idle |

## Verification
The bench builds the block with a 24-cycle settle interval, a 40-cycle error window, a threshold of three errors, a 6-cycle store wait and a 16-cycle hang limit. These values let it walk the whole tier ladder inside one run. It lets the window expire and also re-arms it just short of expiry, and it times every hang escalation to the exact cycle. Expected cycle counts come from those parameters. The expected tier at each step comes from the number of errors injected since the last window expiry.

// File: rtl/link_recovery_pkg.sv
package link_recovery_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DRAIN,
        ST_POISON,
        ST_SETTLE,
        ST_ACK,
        ST_REINIT,
        ST_SLOWINIT,
        ST_SCRUB_GO,
        ST_SCRUB_WAIT,
        ST_QUIESCE,
        ST_RETRY,
        ST_FATAL
    } rec_state_e;

    typedef enum logic [1:0] {
        TIER_NONE    = 2'd0,
        TIER_RETRY   = 2'd1,
        TIER_REINIT  = 2'd2,
        TIER_DEGRADE = 2'd3
    } tier_e;

endpackage

// File: rtl/lrc_err_window.sv
// Counts accepted errors and remembers a recent tier-2 recovery; both are
// forgotten after WINDOW_CYC idle cycles with no new error.
module lrc_err_window #(
    parameter int WINDOW_CYC = 100000,
    parameter int ERR_THRESH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic err_evt,
    input  logic t2_mark,
    input  logic busy,
    output logic at_thresh,
    output logic recent_t2
);
    localparam int CNT_W  = $clog2(ERR_THRESH + 1);
    localparam int IDLE_W = $clog2(WINDOW_CYC + 1);
    localparam logic [CNT_W-1:0]  CNT_SAT = CNT_W'(ERR_THRESH);
    localparam logic [CNT_W-1:0]  CNT_HIT = CNT_W'(ERR_THRESH - 1);
    localparam logic [IDLE_W-1:0] WIN_END = IDLE_W'(WINDOW_CYC - 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [IDLE_W-1:0] idle;
        logic              recent;
    } win_t;

    win_t win_d, win_q;

    always_comb begin
        win_d = win_q;
        if (err_evt) begin
            win_d.cnt  = (win_q.cnt == CNT_SAT) ? win_q.cnt : win_q.cnt + 1'b1;
            win_d.idle = '0;
        end else if (t2_mark) begin
            win_d.recent = 1'b1;
            win_d.idle   = '0;
        end else if (!busy && (win_q.cnt != '0 || win_q.recent)) begin
            if (win_q.idle == WIN_END) begin
                win_d.cnt    = '0;
                win_d.recent = 1'b0;
                win_d.idle   = '0;
            end else begin
                win_d.idle = win_q.idle + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    assign at_thresh = (win_q.cnt >= CNT_HIT);
    assign recent_t2 = win_q.recent;

    // R11: the count cannot move while a recovery is running
    assert_cnt_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(win_q.cnt));

endmodule

// File: rtl/lrc_store_watch.sv
// Holds the newest store until STORE_WAIT cycles pass without a CRC error.
module lrc_store_watch #(
    parameter int STORE_WAIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic store_issue,
    input  logic err_in,
    output logic store_retire
);
    localparam int SW_W = $clog2(STORE_WAIT + 1);
    localparam logic [SW_W-1:0] SW_END = SW_W'(STORE_WAIT);

    typedef struct packed {
        logic            pending;
        logic [SW_W-1:0] cnt;
        logic            retire;
    } sw_t;

    sw_t sw_d, sw_q;

    always_comb begin
        sw_d        = sw_q;
        sw_d.retire = 1'b0;
        if (err_in) begin
            sw_d.pending = 1'b0;
        end else if (store_issue) begin
            sw_d.pending = 1'b1;
            sw_d.cnt     = SW_W'(1);
        end else if (sw_q.pending) begin
            if (sw_q.cnt == SW_END) begin
                sw_d.retire  = 1'b1;
                sw_d.pending = 1'b0;
            end else begin
                sw_d.cnt = sw_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sw_q <= '0;
        else        sw_q <= sw_d;
    end

    assign store_retire = sw_q.retire;

    // R10: a retire never follows a cycle that saw a CRC error
    assert_retire_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
        store_retire |-> !$past(err_in));

endmodule

// File: rtl/link_recovery_ctrl.sv
module link_recovery_ctrl
    import link_recovery_pkg::*;
#(
    parameter int NUM_CH     = 5,
    parameter int SETTLE_CYC = 550,
    parameter int WINDOW_CYC = 100000,
    parameter int ERR_THRESH = 3,
    parameter int STORE_WAIT = 64,
    parameter int HANG_CYC   = 4096,
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            poison_in,
    input  logic            crc_err,
    input  logic [CH_W-1:0] err_ch,
    input  logic            ops_drained,
    input  logic            store_issue,
    input  logic            reinit_done,
    input  logic            scrub_done,
    output logic            halt_new_ops,
    output logic            send_poison,
    output logic            error_ack,
    output logic            retry_stores,
    output logic            reinit_channel,
    output logic [CH_W-1:0] reinit_ch_idx,
    output logic            reinit_all,
    output logic            degraded_valid,
    output logic [CH_W-1:0] degraded_idx,
    output logic            start_scrub,
    output logic            call_home,
    output logic            fatal,
    output logic            store_retire,
    output logic [1:0]      current_tier
);
    localparam int TMR_TOP = (SETTLE_CYC > HANG_CYC) ? SETTLE_CYC : HANG_CYC;
    localparam int TMR_W   = $clog2(TMR_TOP + 1);
    localparam logic [TMR_W-1:0] TMR_SAT    = TMR_W'(TMR_TOP);
    localparam logic [TMR_W-1:0] SETTLE_END = TMR_W'(SETTLE_CYC - 1);
    localparam logic [TMR_W-1:0] HANG_END   = TMR_W'(HANG_CYC - 1);

    typedef struct packed {
        rec_state_e       st;
        tier_e            tier;
        logic [CH_W-1:0]  ch;
        logic [TMR_W-1:0] tmr;
        logic             deg;
        logic [CH_W-1:0]  deg_ch;
        logic             call;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic err_in, err_evt, t2_mark, busy, at_thresh, recent_t2, hang;

    assign err_in  = poison_in | crc_err;
    assign busy    = (ctl_q.st != ST_IDLE);
    assign err_evt = !busy && err_in;
    assign t2_mark = (ctl_q.st == ST_REINIT) && reinit_done;
    assign hang    = (ctl_q.tmr == HANG_END);

    lrc_err_window #(.WINDOW_CYC(WINDOW_CYC), .ERR_THRESH(ERR_THRESH)) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_evt   (err_evt),
        .t2_mark   (t2_mark),
        .busy      (busy),
        .at_thresh (at_thresh),
        .recent_t2 (recent_t2)
    );

    lrc_store_watch #(.STORE_WAIT(STORE_WAIT)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .store_issue  (store_issue),
        .err_in       (err_in),
        .store_retire (store_retire)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.tmr = (ctl_q.tmr == TMR_SAT) ? ctl_q.tmr : ctl_q.tmr + 1'b1;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (err_in) begin
                    ctl_d.st = ST_DRAIN;
                    ctl_d.ch = err_ch;
                    if (ctl_q.deg || recent_t2) ctl_d.tier = TIER_DEGRADE;
                    else if (at_thresh)         ctl_d.tier = TIER_REINIT;
                    else                        ctl_d.tier = TIER_RETRY;
                end
            end
            ST_DRAIN: begin
                if (ops_drained) begin
                    ctl_d.st = ST_POISON;
                end else if (hang) begin
                    if (ctl_q.tier == TIER_DEGRADE) begin
                        ctl_d.st = ST_FATAL;
                    end else begin
                        ctl_d.st   = ST_POISON;
                        ctl_d.tier = tier_e'(ctl_q.tier + 2'd1);
                    end
                end
            end
            ST_POISON: ctl_d.st = ST_SETTLE;
            ST_SETTLE: if (ctl_q.tmr == SETTLE_END) ctl_d.st = ST_ACK;
            ST_ACK: begin
                if (ctl_q.deg) begin
                    ctl_d.st = ST_QUIESCE;
                end else if (ctl_q.tier == TIER_REINIT) begin
                    ctl_d.st = ST_REINIT;
                end else if (ctl_q.tier == TIER_DEGRADE) begin
                    ctl_d.st     = ST_SLOWINIT;
                    ctl_d.deg    = 1'b1;
                    ctl_d.deg_ch = ctl_q.ch;
                end else begin
                    ctl_d.st = ST_RETRY;
                end
            end
            ST_REINIT: begin
                if (reinit_done) begin
                    ctl_d.st = ST_RETRY;
                end else if (hang) begin
                    ctl_d.st     = ST_SLOWINIT;
                    ctl_d.tier   = TIER_DEGRADE;
                    ctl_d.deg    = 1'b1;
                    ctl_d.deg_ch = ctl_q.ch;
                end
            end
            ST_SLOWINIT: begin
                if (reinit_done) ctl_d.st = ST_SCRUB_GO;
                else if (hang)   ctl_d.st = ST_FATAL;
            end
            ST_SCRUB_GO: ctl_d.st = ST_SCRUB_WAIT;
            ST_SCRUB_WAIT: begin
                if (scrub_done) begin
                    ctl_d.st   = ST_RETRY;
                    ctl_d.call = 1'b1;
                end else if (hang) begin
                    ctl_d.st = ST_FATAL;
                end
            end
            ST_QUIESCE: begin
                if (reinit_done) ctl_d.st = ST_RETRY;
                else if (hang)   ctl_d.st = ST_FATAL;
            end
            ST_RETRY: begin
                ctl_d.st   = ST_IDLE;
                ctl_d.tier = TIER_NONE;
            end
            ST_FATAL: ctl_d.st = ST_FATAL;
            default:  ctl_d.st = ST_IDLE;
        endcase
        if (ctl_d.st != ctl_q.st) ctl_d.tmr = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.st   <= ST_IDLE;
            ctl_q.tier <= TIER_NONE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign halt_new_ops   = busy;
    assign send_poison    = (ctl_q.st == ST_POISON);
    assign error_ack      = (ctl_q.st == ST_ACK);
    assign retry_stores   = (ctl_q.st == ST_RETRY);
    assign reinit_channel = (ctl_q.st == ST_REINIT);
    assign reinit_ch_idx  = ctl_q.ch;
    assign reinit_all     = (ctl_q.st == ST_SLOWINIT) || (ctl_q.st == ST_QUIESCE);
    assign start_scrub    = (ctl_q.st == ST_SCRUB_GO);
    assign degraded_valid = ctl_q.deg;
    assign degraded_idx   = ctl_q.deg_ch;
    assign call_home      = ctl_q.call;
    assign fatal          = (ctl_q.st == ST_FATAL);
    assign current_tier   = ctl_q.tier;

    assert_poison_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        send_poison |=> !send_poison);
    assert_ack_halted_R2: assert property (@(posedge clk) disable iff (!rst_n)
        error_ack |-> halt_new_ops);
    assert_tier_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        halt_new_ops != (current_tier == 2'd0));
    assert_degraded_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        degraded_valid |=> degraded_valid && $stable(degraded_idx));
    assert_fatal_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fatal |=> fatal && halt_new_ops && !retry_stores);

endmodule

// File: tb/link_recovery_ctrl_test.sv
module link_recovery_ctrl_test;
    localparam int NCH = 5, SET = 24, WIN = 40, THR = 3, SW = 6, HNG = 16;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, poison_in, crc_err, ops_drained, store_issue, reinit_done, scrub_done;
    logic [2:0] err_ch;
    logic halt_new_ops, send_poison, error_ack, retry_stores, reinit_channel;
    logic reinit_all, degraded_valid, start_scrub, call_home, fatal, store_retire;
    logic [2:0] reinit_ch_idx, degraded_idx;
    logic [1:0] current_tier;

    int n_chk = 0, n_fail = 0, n_retire = 0, n_retry = 0;

    link_recovery_ctrl #(.NUM_CH(NCH), .SETTLE_CYC(SET), .WINDOW_CYC(WIN), .ERR_THRESH(THR),
                         .STORE_WAIT(SW), .HANG_CYC(HNG)) uut (
        .clk(clk), .rst_n(rst_n), .poison_in(poison_in), .crc_err(crc_err), .err_ch(err_ch),
        .ops_drained(ops_drained), .store_issue(store_issue), .reinit_done(reinit_done),
        .scrub_done(scrub_done), .halt_new_ops(halt_new_ops), .send_poison(send_poison),
        .error_ack(error_ack), .retry_stores(retry_stores), .reinit_channel(reinit_channel),
        .reinit_ch_idx(reinit_ch_idx), .reinit_all(reinit_all), .degraded_valid(degraded_valid),
        .degraded_idx(degraded_idx), .start_scrub(start_scrub), .call_home(call_home),
        .fatal(fatal), .store_retire(store_retire), .current_tier(current_tier)
    );

    always @(negedge clk) begin
        if (store_retire) n_retire++;
        if (retry_stores) n_retry++;
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(string rq, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    function automatic bit sel(int code);
        case (code)
            0:       return send_poison;
            1:       return error_ack;
            2:       return retry_stores;
            3:       return reinit_all;
            default: return fatal;
        endcase
    endfunction

    task automatic wait_sig(int code, int lim, output int n);
        n = 0;
        while (!sel(code) && n < lim) begin
            step();
            n++;
        end
    endtask

    task automatic inject(bit use_crc, int ch);
        err_ch = 3'(ch);
        if (use_crc) crc_err = 1'b1;
        else         poison_in = 1'b1;
        step();
        crc_err   = 1'b0;
        poison_in = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; poison_in = 1'b0; crc_err = 1'b0; err_ch = 3'd0;
        ops_drained = 1'b1; store_issue = 1'b0; reinit_done = 1'b1; scrub_done = 1'b1;
        repeat (3) step();
        rst_n = 1'b1;
        step();
    endtask

    // path: 1 retry, 2 channel re-init, 3 degrade+scrub, 4 degraded quiesce
    task automatic follow(int path, int tier, int ch, bit use_crc, int drain_hold, bit poke, string rq);
        int n;
        bit ok;
        int pw;
        if (drain_hold > 0) ops_drained = 1'b0;
        inject(use_crc, ch);
        chk("R2", "halt after error", int'(halt_new_ops), 1);
        chk(rq, "tier during recovery", int'(current_tier), tier);
        if (drain_hold > 0) begin
            ok = 1'b1;
            for (int i = 0; i < drain_hold; i++) begin
                if (send_poison || !halt_new_ops) ok = 1'b0;
                step();
            end
            chk("R2", "no poison before drain", int'(ok), 1);
            ops_drained = 1'b1;
            step();
            chk("R2", "poison after drain", int'(send_poison), 1);
        end else begin
            wait_sig(0, 4 * HNG, n);
            chk("R2", "cycles halt to poison", n, 1);
        end
        n = 0;
        pw = 0;
        while (!error_ack && n < 4 * SET) begin
            if (poke && n == 3) poison_in = 1'b1;
            step();
            poison_in = 1'b0;
            n++;
            if (n == 1) pw = int'(send_poison);
        end
        chk("R3", "poison pulse width", pw, 0);
        chk("R3", "poison to ack cycles", n, SET + 1);
        case (path)
            1: begin
                step();
                chk(rq, "retry after ack", int'(retry_stores), 1);
            end
            2: begin
                step();
                chk("R4", "reinit_channel", int'(reinit_channel), 1);
                chk("R4", "reinit index", int'(reinit_ch_idx), ch);
                step();
                chk("R4", "retry after reinit", int'(retry_stores), 1);
            end
            3: begin
                step();
                chk("R6", "slow reinit", int'(reinit_all), 1);
                chk("R6", "degraded valid", int'(degraded_valid), 1);
                chk("R6", "degraded index", int'(degraded_idx), ch);
                step();
                chk("R6", "scrub start", int'(start_scrub), 1);
                step();
                chk("R6", "scrub pulse width", int'(start_scrub), 0);
                step();
                chk("R6", "retry after scrub", int'(retry_stores), 1);
                chk("R6", "call home", int'(call_home), 1);
            end
            default: begin
                step();
                chk("R7", "fast reinit in degraded mode", int'(reinit_all), 1);
                step();
                chk("R7", "retry after quiesce", int'(retry_stores), 1);
            end
        endcase
        step();
        chk(rq, "halt released", int'(halt_new_ops), 0);
        chk("R4", "tier idle", int'(current_tier), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n, r0;
        do_reset();
        // R1 reset state
        chk("R1", "halt", int'(halt_new_ops), 0);
        chk("R1", "pulses", int'(send_poison | error_ack | retry_stores | start_scrub), 0);
        chk("R1", "reinit", int'(reinit_channel | reinit_all), 0);
        chk("R1", "sticky flags", int'(degraded_valid | call_home | fatal | store_retire), 0);
        chk("R1", "tier", int'(current_tier), 0);

        // R10 store retire after SW cycles
        store_issue = 1'b1; step(); store_issue = 1'b0;
        for (int i = 1; i <= SW; i++) begin
            step();
            if (i == SW - 1) chk("R10", "no early retire", int'(store_retire), 0);
            if (i == SW)     chk("R10", "retire on time", int'(store_retire), 1);
        end
        step();
        chk("R10", "retire one cycle", int'(store_retire), 0);
        // R10 cancel by error (count -> 1)
        r0 = n_retire;
        store_issue = 1'b1; step(); store_issue = 1'b0;
        step(); step();
        follow(1, 1, 0, 1'b1, 0, 1'b0, "R10");
        repeat (SW) step();
        chk("R10", "cancelled store never retires", n_retire - r0, 0);

        repeat (WIN + 5) step();
        // count restarts: 1 then 2 (poke ignored), 3 -> tier 2
        follow(1, 1, 0, 1'b0, 0, 1'b1, "R4");
        follow(1, 1, 1, 1'b1, 6, 1'b0, "R11");
        follow(2, 2, 3, 1'b0, 0, 1'b0, "R4");
        // R5 window expiry clears count and recent tier-2
        repeat (WIN + 5) step();
        follow(1, 1, 2, 1'b1, 0, 1'b0, "R5");
        follow(1, 1, 0, 1'b0, 0, 1'b0, "R5");
        follow(2, 2, 1, 1'b1, 0, 1'b0, "R4");
        repeat (WIN - 15) step();
        follow(3, 3, 4, 1'b0, 0, 1'b0, "R6");
        // R7 degraded further error
        follow(4, 3, 1, 1'b1, 0, 1'b0, "R7");
        chk("R7", "degraded index unchanged", int'(degraded_idx), 4);
        chk("R6", "call home sticky", int'(call_home), 1);

        // R9 quiesce hang -> fatal
        reinit_done = 1'b0;
        inject(1'b0, 2);
        wait_sig(1, 4 * SET, n);
        step();
        chk("R9", "quiesce entered", int'(reinit_all), 1);
        r0 = n_retry;
        wait_sig(4, 4 * HNG, n);
        chk("R9", "cycles to fatal", n, HNG);
        repeat (5) step();
        chk("R9", "fatal sticky", int'(fatal), 1);
        chk("R9", "halt held", int'(halt_new_ops), 1);
        chk("R9", "tier 3", int'(current_tier), 3);
        chk("R9", "no retry", n_retry - r0, 0);

        do_reset();
        chk("R1", "flags clear after reset", int'(fatal | degraded_valid | call_home), 0);

        // R8 drain hang escalates 1 -> 2, reinit hang escalates 2 -> 3
        ops_drained = 1'b0; reinit_done = 1'b0;
        inject(1'b1, 2);
        wait_sig(0, 4 * HNG, n);
        chk("R8", "drain hang cycles", n, HNG);
        chk("R8", "tier after drain hang", int'(current_tier), 2);
        ops_drained = 1'b1;
        wait_sig(1, 4 * SET, n);
        step();
        chk("R8", "reinit_channel", int'(reinit_channel), 1);
        wait_sig(3, 4 * HNG, n);
        chk("R8", "reinit hang cycles", n, HNG);
        chk("R8", "degraded on escalation", int'(degraded_valid), 1);
        chk("R8", "degraded index", int'(degraded_idx), 2);
        chk("R8", "tier after reinit hang", int'(current_tier), 3);
        reinit_done = 1'b1;
        step();
        chk("R6", "scrub after escalated slow init", int'(start_scrub), 1);
        step(); step();
        chk("R6", "retry after escalated scrub", int'(retry_stores), 1);
        chk("R6", "call home after escalation", int'(call_home), 1);
        step();
        chk("R8", "idle after escalated recovery", int'(halt_new_ops), 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule